// File: doc/BRIEF.md
# Log-Structured Compressed Line Allocator

This block decides where compressed cache lines go inside a small array of fixed-size physical log slots. Each request carries a line address, a data-type class and the compressed length in bytes. The line is appended to the log that is currently open for that class, packed at byte granularity right after the previous line. Stale copies are never overwritten in place. Any older valid copy of the same address is invalidated when the new copy is appended, and a separate command can invalidate any tag position directly. Payload storage, compression and memory traffic lie outside the block. It reports only the slot, byte offset and entry index chosen for each line, plus an eviction request whenever a slot that still holds live lines has to be reclaimed.

When an append does not fit, either because the bytes would run past the end of the slot or because every tag position is taken, a victim slot is reclaimed and the line is placed at its start. A slot with no valid entries is preferred and costs no writeback. Only when no such slot is available is a victim taken in round-robin FIFO order. A combinational lookup port gives the tag comparison: it returns the position and modified state of the one valid entry that matches an address.

Top module: `logAllocTop`

## Requirements
- R1: After reset, all slots are empty, no address hits on the lookup port, doneValid and evictValid are low, class c appends into slot c, and the FIFO victim pointer is at slot 0.
- R2: An accepted request produces a one-cycle doneValid pulse in the next cycle. Within a slot, the reported byte offset equals the sum of the lengths of the lines appended there before it, and the entry index counts up from 0 in append order.
- R3: A request whose address matches a valid entry invalidates that entry, and the line is appended as a new entry. Afterwards the lookup port returns the new position.
- R4: An invalidate command (slot, entry) takes effect at the next clock edge. An entry that has been invalidated never matches on the lookup port.
- R5: A line appended by a write (reqWrite=1) reads back on the lookup port with lkDirty=1. A line appended by a refill (reqWrite=0) reads back with lkDirty=0.
- R6: Each class keeps its own open slot, so appends of different classes go to different slots and have independent offsets.
- R7: If the current fill of the open slot plus reqLen exceeds 512 bytes, the line is placed at offset 0, entry 0 of a reclaimed slot, and that slot becomes the class's open slot.
- R8: An append to a slot that already holds 16 entries is treated as an overflow, in the same way as R7.
- R9: On overflow, the lowest-index slot that holds no valid entry and is not the open slot of another class is reclaimed. No eviction pulse is raised, and the FIFO pointer does not move.
- R10: If no slot qualifies under R9, the slot at the FIFO pointer is reclaimed and the pointer advances by one, modulo the slot count. evictValid pulses together with doneValid and evictSlot names that slot if it held any valid entry. Its former lines then no longer match.
- R11: An append that fills the slot to exactly 512 bytes fits and does not overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Append request strobe |
| reqWrite | input | 1 | 1 = write (line becomes modified), 0 = refill |
| reqAddr | input | ADDR_W | Line address (tag) |
| reqClass | input | CLASS_W | Data-type class selecting the open slot |
| reqLen | input | LEN_W | Compressed length in bytes, 1 to SLOT_BYTES |
| invValid | input | 1 | Invalidate-entry command strobe |
| invSlot | input | SLOT_W | Slot of the entry to invalidate |
| invEntry | input | ENT_W | Entry index to invalidate |
| lkAddr | input | ADDR_W | Lookup address |
| lkHit | output | 1 | A valid entry matches lkAddr |
| lkSlot | output | SLOT_W | Slot of the matching entry |
| lkEntry | output | ENT_W | Entry index of the matching entry |
| lkDirty | output | 1 | Matching entry is modified |
| doneValid | output | 1 | Append completed (one cycle after the request) |
| doneSlot | output | SLOT_W | Slot the line was placed in |
| doneOffset | output | LEN_W | Byte offset of the line inside the slot |
| doneEntry | output | ENT_W | Tag entry index of the line |
| evictValid | output | 1 | A slot holding live lines was reclaimed |
| evictSlot | output | SLOT_W | Slot to be written back |

## Verification
Appends use varied lengths across two classes, so that byte packing and per-class separation show up as distinct offsets and slots. The append patterns also reach both overflow triggers separately: a run of one-byte lines exhausts the tag positions, while a single long line exhausts the bytes, and an exact-fit line shows where the capacity boundary lies. Reclaim cases are arranged so that an empty slot, a slot emptied by invalidation, another class's open slot and slots that are fully live each become the candidate in turn. This separates the free-slot preference from the FIFO fallback and shows the pointer advancing. Repeated writes to one address and explicit invalidations, each followed by lookups, tell stale copies apart from live ones.

// File: rtl/logAllocPkg.sv
package logAllocPkg;
  // Strobes from the control to the datapath for one request cycle.
  typedef struct packed {
    logic append;   // place the request line this cycle
    logic reclaim;  // target slot is restarted at offset 0
    logic useFifo;  // victim came from the FIFO pointer
    logic evict;    // victim still held live lines
  } allocStrobe_t;
endpackage

// File: rtl/logAllocCtrl.sv
module logAllocCtrl
  import logAllocPkg::*;
#(
  parameter int NUM_SLOTS   = 4,
  parameter int SLOT_BYTES  = 512,
  parameter int MAX_ENTRIES = 16,
  localparam int SLOT_W = $clog2(NUM_SLOTS),
  localparam int LEN_W  = $clog2(SLOT_BYTES + 1),
  localparam int CNT_W  = $clog2(MAX_ENTRIES + 1)
) (
  input  logic                 reqValid,
  input  logic [LEN_W-1:0]     reqLen,
  input  logic [SLOT_W-1:0]    actSlot,
  input  logic [LEN_W-1:0]     actFill,
  input  logic [CNT_W-1:0]     actCnt,
  input  logic [NUM_SLOTS-1:0] liveAny,
  input  logic [NUM_SLOTS-1:0] otherActive,
  input  logic [SLOT_W-1:0]    fifoPtr,
  output allocStrobe_t         st,
  output logic [SLOT_W-1:0]    tgtSlot
);
  logic                 overflow;
  logic [NUM_SLOTS-1:0] cand;
  logic                 freeHit;
  logic [SLOT_W-1:0]    freeSlot;

  always_comb begin
    overflow = (({1'b0, actFill} + {1'b0, reqLen}) > (LEN_W + 1)'(SLOT_BYTES))
               || (actCnt == CNT_W'(MAX_ENTRIES));
  end

  // Reclaimable without writeback: no live entry, not open for another class.
  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_cand
    assign cand[s] = !liveAny[s] && ((SLOT_W'(s) == actSlot) || !otherActive[s]);
  end

  always_comb begin
    freeHit  = 1'b0;
    freeSlot = '0;
    for (int s = NUM_SLOTS - 1; s >= 0; s--) begin
      if (cand[s]) begin
        freeHit  = 1'b1;
        freeSlot = SLOT_W'(s);
      end
    end
  end

  always_comb begin
    st      = '0;
    tgtSlot = actSlot;
    if (reqValid) begin
      st.append = 1'b1;
      if (overflow) begin
        st.reclaim = 1'b1;
        if (freeHit) begin
          tgtSlot = freeSlot;
        end else begin
          tgtSlot    = fifoPtr;
          st.useFifo = 1'b1;
          st.evict   = liveAny[fifoPtr];
        end
      end
    end
  end
endmodule

// File: rtl/logAllocData.sv
module logAllocData
  import logAllocPkg::*;
#(
  parameter int NUM_SLOTS   = 4,
  parameter int SLOT_BYTES  = 512,
  parameter int MAX_ENTRIES = 16,
  parameter int NUM_CLASSES = 2,
  parameter int ADDR_W      = 16,
  localparam int SLOT_W  = $clog2(NUM_SLOTS),
  localparam int ENT_W   = $clog2(MAX_ENTRIES),
  localparam int LEN_W   = $clog2(SLOT_BYTES + 1),
  localparam int CNT_W   = $clog2(MAX_ENTRIES + 1),
  localparam int CLASS_W = $clog2(NUM_CLASSES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic [CLASS_W-1:0]   reqClass,
  input  logic [LEN_W-1:0]     reqLen,
  input  logic                 invValid,
  input  logic [SLOT_W-1:0]    invSlot,
  input  logic [ENT_W-1:0]     invEntry,
  input  logic [ADDR_W-1:0]    lkAddr,
  output logic                 lkHit,
  output logic [SLOT_W-1:0]    lkSlot,
  output logic [ENT_W-1:0]     lkEntry,
  output logic                 lkDirty,
  input  allocStrobe_t         st,
  input  logic [SLOT_W-1:0]    tgtSlot,
  output logic [SLOT_W-1:0]    actSlot,
  output logic [LEN_W-1:0]     actFill,
  output logic [CNT_W-1:0]     actCnt,
  output logic [NUM_SLOTS-1:0] liveAny,
  output logic [NUM_SLOTS-1:0] otherActive,
  output logic [SLOT_W-1:0]    fifoPtr,
  output logic                 doneValid,
  output logic [SLOT_W-1:0]    doneSlot,
  output logic [LEN_W-1:0]     doneOffset,
  output logic [ENT_W-1:0]     doneEntry,
  output logic                 evictValid,
  output logic [SLOT_W-1:0]    evictSlot
);
  typedef struct packed {
    logic              hit;
    logic [SLOT_W-1:0] slot;
    logic [ENT_W-1:0]  ent;
  } match_t;

  logic [MAX_ENTRIES-1:0] vMask   [NUM_SLOTS];
  logic [MAX_ENTRIES-1:0] dMask   [NUM_SLOTS];
  logic [MAX_ENTRIES-1:0] postMask[NUM_SLOTS];
  logic [ADDR_W-1:0]      tagMem  [NUM_SLOTS][MAX_ENTRIES];
  logic [LEN_W-1:0]       fill    [NUM_SLOTS];
  logic [CNT_W-1:0]       cnt     [NUM_SLOTS];
  logic [SLOT_W-1:0]      actTab  [NUM_CLASSES];
  logic [SLOT_W-1:0]      fifoQ;
  match_t                 reqM, lkM;
  logic [ENT_W-1:0]       wrEnt;

  function automatic match_t findTag(input logic [ADDR_W-1:0] a);
    match_t m = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      for (int e = 0; e < MAX_ENTRIES; e++)
        if (!m.hit && vMask[s][e] && tagMem[s][e] == a) begin
          m.hit  = 1'b1;
          m.slot = SLOT_W'(s);
          m.ent  = ENT_W'(e);
        end
    return m;
  endfunction

  always_comb begin
    reqM = findTag(reqAddr);
    lkM  = findTag(lkAddr);
  end

  assign lkHit   = lkM.hit;
  assign lkSlot  = lkM.slot;
  assign lkEntry = lkM.ent;
  assign lkDirty = lkM.hit && dMask[lkM.slot][lkM.ent];

  // Valid masks after this cycle's invalidations (old copy and command).
  always_comb begin
    for (int s = 0; s < NUM_SLOTS; s++) begin
      postMask[s] = vMask[s];
      if (reqValid && reqM.hit && reqM.slot == SLOT_W'(s)) postMask[s][reqM.ent] = 1'b0;
      if (invValid && invSlot == SLOT_W'(s)) postMask[s][invEntry] = 1'b0;
      liveAny[s] = |postMask[s];
      otherActive[s] = 1'b0;
      for (int c = 0; c < NUM_CLASSES; c++)
        if (CLASS_W'(c) != reqClass && actTab[c] == SLOT_W'(s)) otherActive[s] = 1'b1;
    end
  end

  assign actSlot = actTab[reqClass];
  assign actFill = fill[actSlot];
  assign actCnt  = cnt[actSlot];
  assign fifoPtr = fifoQ;
  assign wrEnt   = st.reclaim ? '0 : cnt[tgtSlot][ENT_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < NUM_SLOTS; s++) begin
        vMask[s] <= '0;
        dMask[s] <= '0;
        fill[s]  <= '0;
        cnt[s]   <= '0;
      end
      for (int c = 0; c < NUM_CLASSES; c++) actTab[c] <= SLOT_W'(c % NUM_SLOTS);
      fifoQ      <= '0;
      doneValid  <= 1'b0;
      doneSlot   <= '0;
      doneOffset <= '0;
      doneEntry  <= '0;
      evictValid <= 1'b0;
      evictSlot  <= '0;
    end else begin
      for (int s = 0; s < NUM_SLOTS; s++) vMask[s] <= postMask[s];
      doneValid  <= st.append;
      evictValid <= st.evict;
      if (st.append) begin
        doneSlot   <= tgtSlot;
        evictSlot  <= tgtSlot;
        doneEntry  <= wrEnt;
        doneOffset <= st.reclaim ? '0 : fill[tgtSlot];
        actTab[reqClass] <= tgtSlot;
        if (st.reclaim) begin
          vMask[tgtSlot] <= MAX_ENTRIES'(1);
          dMask[tgtSlot] <= MAX_ENTRIES'(reqWrite);
          fill[tgtSlot]  <= reqLen;
          cnt[tgtSlot]   <= CNT_W'(1);
        end else begin
          vMask[tgtSlot][wrEnt] <= 1'b1;
          dMask[tgtSlot][wrEnt] <= reqWrite;
          fill[tgtSlot]  <= fill[tgtSlot] + reqLen;
          cnt[tgtSlot]   <= cnt[tgtSlot] + 1'b1;
        end
      end
      if (st.useFifo)
        fifoQ <= (fifoQ == SLOT_W'(NUM_SLOTS - 1)) ? '0 : fifoQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (st.append) tagMem[tgtSlot][wrEnt] <= reqAddr;
  end
endmodule

// File: rtl/logAllocTop.sv
module logAllocTop
  import logAllocPkg::*;
#(
  parameter int NUM_SLOTS   = 4,
  parameter int SLOT_BYTES  = 512,
  parameter int MAX_ENTRIES = 16,
  parameter int NUM_CLASSES = 2,
  parameter int ADDR_W      = 16,
  localparam int SLOT_W  = $clog2(NUM_SLOTS),
  localparam int ENT_W   = $clog2(MAX_ENTRIES),
  localparam int LEN_W   = $clog2(SLOT_BYTES + 1),
  localparam int CNT_W   = $clog2(MAX_ENTRIES + 1),
  localparam int CLASS_W = $clog2(NUM_CLASSES)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  input  logic               reqWrite,
  input  logic [ADDR_W-1:0]  reqAddr,
  input  logic [CLASS_W-1:0] reqClass,
  input  logic [LEN_W-1:0]   reqLen,
  input  logic               invValid,
  input  logic [SLOT_W-1:0]  invSlot,
  input  logic [ENT_W-1:0]   invEntry,
  input  logic [ADDR_W-1:0]  lkAddr,
  output logic               lkHit,
  output logic [SLOT_W-1:0]  lkSlot,
  output logic [ENT_W-1:0]   lkEntry,
  output logic               lkDirty,
  output logic               doneValid,
  output logic [SLOT_W-1:0]  doneSlot,
  output logic [LEN_W-1:0]   doneOffset,
  output logic [ENT_W-1:0]   doneEntry,
  output logic               evictValid,
  output logic [SLOT_W-1:0]  evictSlot
);
  allocStrobe_t         st;
  logic [SLOT_W-1:0]    tgtSlot, actSlot, fifoPtr;
  logic [LEN_W-1:0]     actFill;
  logic [CNT_W-1:0]     actCnt;
  logic [NUM_SLOTS-1:0] liveAny, otherActive;

  logAllocCtrl #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_BYTES(SLOT_BYTES), .MAX_ENTRIES(MAX_ENTRIES)
  ) u_ctrl (
    .reqValid(reqValid), .reqLen(reqLen), .actSlot(actSlot), .actFill(actFill),
    .actCnt(actCnt), .liveAny(liveAny), .otherActive(otherActive),
    .fifoPtr(fifoPtr), .st(st), .tgtSlot(tgtSlot)
  );

  logAllocData #(
    .NUM_SLOTS(NUM_SLOTS), .SLOT_BYTES(SLOT_BYTES), .MAX_ENTRIES(MAX_ENTRIES),
    .NUM_CLASSES(NUM_CLASSES), .ADDR_W(ADDR_W)
  ) u_data (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqClass(reqClass), .reqLen(reqLen),
    .invValid(invValid), .invSlot(invSlot), .invEntry(invEntry),
    .lkAddr(lkAddr), .lkHit(lkHit), .lkSlot(lkSlot), .lkEntry(lkEntry),
    .lkDirty(lkDirty), .st(st), .tgtSlot(tgtSlot), .actSlot(actSlot),
    .actFill(actFill), .actCnt(actCnt), .liveAny(liveAny),
    .otherActive(otherActive), .fifoPtr(fifoPtr), .doneValid(doneValid),
    .doneSlot(doneSlot), .doneOffset(doneOffset), .doneEntry(doneEntry),
    .evictValid(evictValid), .evictSlot(evictSlot)
  );
endmodule

// File: rtl/logAllocChk.sv
module logAllocChk #(
  parameter int SLOT_BYTES = 512,
  parameter int ADDR_W     = 16,
  parameter int SLOT_W     = 2,
  parameter int ENT_W      = 4,
  parameter int LEN_W      = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [ADDR_W-1:0] lkAddr,
  input logic              lkHit,
  input logic [SLOT_W-1:0] lkSlot,
  input logic [ENT_W-1:0]  lkEntry,
  input logic              lkDirty,
  input logic              doneValid,
  input logic [SLOT_W-1:0] doneSlot,
  input logic [LEN_W-1:0]  doneOffset,
  input logic [ENT_W-1:0]  doneEntry,
  input logic              evictValid,
  input logic [SLOT_W-1:0] evictSlot
);
  p_done_follows_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> doneValid);

  p_no_spurious_done_r2: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !doneValid);

  p_offset_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> doneOffset < LEN_W'(SLOT_BYTES));

  p_evict_with_done_r10: assert property (@(posedge clk) disable iff (!rstN)
    evictValid |-> doneValid && evictSlot == doneSlot);

  p_reclaim_at_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    evictValid |-> doneOffset == '0 && doneEntry == '0);

  // R3 and R5: the freshly appended copy is the one the lookup sees.
  p_new_copy_visible_r3: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && lkAddr == $past(reqAddr)) |->
      (lkHit && lkSlot == doneSlot && lkEntry == doneEntry && lkDirty == $past(reqWrite)));
endmodule

bind logAllocTop logAllocChk #(
  .SLOT_BYTES(SLOT_BYTES), .ADDR_W(ADDR_W), .SLOT_W(SLOT_W),
  .ENT_W(ENT_W), .LEN_W(LEN_W)
) u_chk (.*);

// File: tb/logAllocTop_tb.sv
module logAllocTop_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0, reqWrite = 1'b0;
  logic [15:0] reqAddr = '0;
  logic        reqClass = 1'b0;
  logic [9:0]  reqLen = '0;
  logic        invValid = 1'b0;
  logic [1:0]  invSlot = '0;
  logic [3:0]  invEntry = '0;
  logic [15:0] lkAddr = '0;
  logic        lkHit, lkDirty, doneValid, evictValid;
  logic [1:0]  lkSlot, doneSlot, evictSlot;
  logic [3:0]  lkEntry, doneEntry;
  logic [9:0]  doneOffset;

  int nChecks = 0;
  int nFail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  logAllocTop u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqClass(reqClass), .reqLen(reqLen),
    .invValid(invValid), .invSlot(invSlot), .invEntry(invEntry),
    .lkAddr(lkAddr), .lkHit(lkHit), .lkSlot(lkSlot), .lkEntry(lkEntry),
    .lkDirty(lkDirty), .doneValid(doneValid), .doneSlot(doneSlot),
    .doneOffset(doneOffset), .doneEntry(doneEntry), .evictValid(evictValid),
    .evictSlot(evictSlot)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Drive one request; on return the done outputs of that request are visible.
  task automatic doAppend(input logic wr, input logic [15:0] addr, input logic cls, input int len);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = addr; reqClass = cls; reqLen = 10'(len);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic expDone(input string req, input int slot, input int off, input int ent,
                         input int ev, input int evSlot);
    chk(req, "doneValid", int'(doneValid), 1);
    chk(req, "doneSlot", int'(doneSlot), slot);
    chk(req, "doneOffset", int'(doneOffset), off);
    chk(req, "doneEntry", int'(doneEntry), ent);
    chk(req, "evictValid", int'(evictValid), ev);
    if (ev != 0) chk(req, "evictSlot", int'(evictSlot), evSlot);
  endtask

  task automatic probe(input string req, input logic [15:0] addr, input int hit,
                       input int slot, input int ent, input int dirty);
    lkAddr = addr;
    #1;
    chk(req, "lkHit", int'(lkHit), hit);
    if (hit != 0) begin
      chk(req, "lkSlot", int'(lkSlot), slot);
      chk(req, "lkEntry", int'(lkEntry), ent);
      chk(req, "lkDirty", int'(lkDirty), dirty);
    end
  endtask

  task automatic doInv(input int slot, input int ent);
    @(negedge clk);
    invValid = 1'b1; invSlot = 2'(slot); invEntry = 4'(ent);
    @(negedge clk);
    invValid = 1'b0;
  endtask

  task automatic testReset();
    chk("R1", "doneValid after reset", int'(doneValid), 0);
    chk("R1", "evictValid after reset", int'(evictValid), 0);
    probe("R1", 16'h0000, 0, 0, 0, 0);
    probe("R1", 16'h0100, 0, 0, 0, 0);
  endtask

  task automatic testPacking();
    doAppend(1'b0, 16'h0100, 1'b0, 100);
    expDone("R2", 0, 0, 0, 0, 0);
    doAppend(1'b0, 16'h0101, 1'b0, 60);
    expDone("R2", 0, 100, 1, 0, 0);
    doAppend(1'b1, 16'h0102, 1'b0, 37);
    expDone("R2", 0, 160, 2, 0, 0);
    @(negedge clk);
    chk("R2", "doneValid drops", int'(doneValid), 0);
    probe("R5", 16'h0100, 1, 0, 0, 0);
    probe("R5", 16'h0102, 1, 0, 2, 1);
  endtask

  task automatic testClasses();
    doAppend(1'b1, 16'h0200, 1'b1, 50);
    expDone("R6", 1, 0, 0, 0, 0);
    doAppend(1'b0, 16'h0103, 1'b0, 3);
    expDone("R6", 0, 197, 3, 0, 0);
  endtask

  task automatic testWriteHit();
    doAppend(1'b1, 16'h0100, 1'b0, 20);
    expDone("R3", 0, 200, 4, 0, 0);
    probe("R3", 16'h0100, 1, 0, 4, 1);
  endtask

  task automatic testInvalidate();
    probe("R4", 16'h0101, 1, 0, 1, 0);
    doInv(0, 1);
    probe("R4", 16'h0101, 0, 0, 0, 0);
    probe("R4", 16'h0102, 1, 0, 2, 1);
  endtask

  task automatic testByteOverflow();
    doAppend(1'b0, 16'h0104, 1'b0, 292);
    expDone("R11", 0, 220, 5, 0, 0);
    doAppend(1'b0, 16'h0105, 1'b0, 10);
    expDone("R7", 2, 0, 0, 0, 0);
    probe("R7", 16'h0104, 1, 0, 5, 0);
  endtask

  task automatic testEntryOverflow();
    for (int i = 1; i <= 15; i++) begin
      doAppend(1'b0, 16'h0300 + 16'(i), 1'b0, 1);
      expDone("R8", 2, 9 + i, i, 0, 0);
    end
    doAppend(1'b0, 16'h0310, 1'b0, 1);
    expDone("R8", 3, 0, 0, 0, 0);
  endtask

  task automatic testFifoVictim();
    doAppend(1'b0, 16'h0400, 1'b0, 512);
    expDone("R10", 0, 0, 0, 1, 0);
    probe("R10", 16'h0104, 0, 0, 0, 0);
    probe("R10", 16'h0100, 0, 0, 0, 0);
    probe("R5", 16'h0400, 1, 0, 0, 0);
  endtask

  task automatic testFreePreferred();
    doInv(3, 0);
    probe("R9", 16'h0310, 0, 0, 0, 0);
    doAppend(1'b1, 16'h0500, 1'b0, 5);
    expDone("R9", 3, 0, 0, 0, 0);
    doAppend(1'b0, 16'h0600, 1'b0, 510);
    expDone("R10", 1, 0, 0, 1, 1);
    probe("R10", 16'h0200, 0, 0, 0, 0);
    doAppend(1'b0, 16'h0700, 1'b1, 4);
    expDone("R10", 2, 0, 0, 1, 2);
    probe("R10", 16'h0305, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testPacking();
    testClasses();
    testWriteHit();
    testInvalidate();
    testByteOverflow();
    testEntryOverflow();
    testFifoVictim();
    testFreePreferred();
    repeat (2) @(negedge clk);
    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", nChecks, nFail);
      $finish;
    end
  end
endmodule